// File: doc/BRIEF.md
# Printer Port Interrupt Controller

This block raises interrupts for a parallel printer port. It watches the printer's acknowledge and fault lines. Both lines are asynchronous to the core clock, so each one passes through a synchronizer before the block looks for edges on it. A qualifying edge sets a sticky pending flag. The interrupt request goes out together with a 3-bit priority level that software has programmed.

Software uses one 8-bit control register on a simple register bus. A write lands in the clock edge where `wr_en` is high. The read value is always visible on `rd_data`. The register holds:

- the level (bits 2..0),
- an enable (bit 3),
- a polarity select for acknowledge (bit 4),
- two pending flags that are cleared by writing a one: acknowledge (bit 5) and fault (bit 6),
- a read-only summary flag (bit 7).

The bus has no handshake: every write completes in one cycle.

Top module: `prn_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and `irq_req` is low.
- R2: A write stores bits 2..0 (level), bit 3 (enable) and bit 4 (acknowledge polarity), and they read back as written. `irq_level` always equals bits 2..0.
- R3: With bit 4 = 0 and bit 3 = 1, a low-to-high transition of `prn_ack` sets bit 5. A high-to-low transition does not set it.
- R4: With bit 4 = 1 and bit 3 = 1, a high-to-low transition of `prn_ack` sets bit 5. A low-to-high transition does not set it.
- R5: A high-to-low transition of `prn_fault_n` sets bit 6 whatever the enable is. A low-to-high transition does not set it.
- R6: Writing a one to bit 5 or bit 6 clears that flag. Writing a zero there leaves the flag unchanged.
- R7: While bit 3 is 0, bit 5 is held at zero and acknowledge edges are discarded. Clearing bit 3 also clears a bit 5 that is already set. Bit 6 is unaffected by the enable.
- R8: Bit 7 reads as the OR of bits 5 and 6. Writes to bit 7 are ignored.
- R9: `irq_req` is high exactly when bit 3 and bit 7 are both set.
- R10: An input transition is reflected in its flag at the third rising clock edge after the pin changes (two synchronizer stages, then the flag register). An edge that reaches the flag in the same cycle as a write-one-to-clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| prn_ack | input | 1 | Printer acknowledge, asynchronous |
| prn_fault_n | input | 1 | Printer fault, active low, asynchronous |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed level sent with the request |

## Verification
The assertions assume two things. First, both printer inputs sit at their idle high level while reset is held, so no spurious edge appears when reset is released. Second, no write is issued during reset.

The stimulus keeps to these rules. It changes inputs only on falling clock edges and holds each pin level for several cycles. The sweeps cover every combination of enable, polarity and edge direction. A write is placed exactly on the edge-arrival cycle to hit the collision case.

// File: rtl/prn_irq_pkg.sv
package prn_irq_pkg;
  localparam int REG_W    = 8;
  localparam int LVL_W    = 3;
  localparam int EN_BIT   = 3;
  localparam int POL_BIT  = 4;
  localparam int ACKF_BIT = 5;
  localparam int FLTF_BIT = 6;
  localparam int SUM_BIT  = 7;

  typedef struct packed {
    logic             pol;
    logic             en;
    logic [LVL_W-1:0] lvl;
  } prn_cfg_t;
endpackage

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/prn_edge.sv
module prn_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic s,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= s;
  end

  assign rise = s & ~prev;
  assign fall = ~s & prev;
endmodule

// File: rtl/prn_irq_ctrl.sv
module prn_irq_ctrl
  import prn_irq_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic ACK_IDLE    = 1'b1,
  parameter logic FLT_IDLE    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             prn_ack,
  input  logic             prn_fault_n,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level
);
  logic ack_s, flt_s;
  logic ack_rise, ack_fall, flt_rise, flt_fall;

  prn_sync #(.STAGES(SYNC_STAGES), .IDLE(ACK_IDLE)) u_ack_sync (
    .clk(clk), .rst(rst), .d(prn_ack), .q(ack_s));
  prn_sync #(.STAGES(SYNC_STAGES), .IDLE(FLT_IDLE)) u_flt_sync (
    .clk(clk), .rst(rst), .d(prn_fault_n), .q(flt_s));

  prn_edge #(.IDLE(ACK_IDLE)) u_ack_edge (
    .clk(clk), .rst(rst), .s(ack_s), .rise(ack_rise), .fall(ack_fall));
  prn_edge #(.IDLE(FLT_IDLE)) u_flt_edge (
    .clk(clk), .rst(rst), .s(flt_s), .rise(flt_rise), .fall(flt_fall));

  prn_cfg_t cfg_q, cfg_d;
  logic     ackf_q, ackf_d, fltf_q, fltf_d;
  logic     ack_evt, flt_evt, clr_ack, clr_flt;

  // polarity picks which synchronized transition counts as acknowledge
  assign ack_evt = cfg_q.pol ? ack_fall : ack_rise;
  assign flt_evt = flt_fall;
  assign clr_ack = wr_en & wr_data[ACKF_BIT];
  assign clr_flt = wr_en & wr_data[FLTF_BIT];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.lvl = wr_data[LVL_W-1:0];
      cfg_d.en  = wr_data[EN_BIT];
      cfg_d.pol = wr_data[POL_BIT];
    end
    // set wins over clear; enable gates the acknowledge flag
    ackf_d = cfg_d.en ? ((ackf_q & ~clr_ack) | ack_evt) : 1'b0;
    fltf_d = (fltf_q & ~clr_flt) | flt_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      ackf_q <= 1'b0;
      fltf_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      ackf_q <= ackf_d;
      fltf_q <= fltf_d;
    end
  end

  logic pend;
  assign pend = ackf_q | fltf_q;

  always_comb begin
    rd_data                 = '0;
    rd_data[LVL_W-1:0]      = cfg_q.lvl;
    rd_data[EN_BIT]         = cfg_q.en;
    rd_data[POL_BIT]        = cfg_q.pol;
    rd_data[ACKF_BIT]       = ackf_q;
    rd_data[FLTF_BIT]       = fltf_q;
    rd_data[SUM_BIT]        = pend;
  end

  assign irq_req   = cfg_q.en & pend;
  assign irq_level = cfg_q.lvl;
endmodule

// File: rtl/prn_irq_chk.sv
module prn_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_req,
  input logic [2:0] irq_level
);
  AST_LEVEL_OUT: assert property (@(posedge clk) disable iff (rst)
    irq_level == rd_data[2:0]); // R2
  AST_CFG_STORE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[4:0] == $past(wr_data[4:0])); // R2
  AST_ZERO_KEEPS_FAULT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[6] && rd_data[6]) |=> rd_data[6]); // R6
  AST_NO_ACK_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !rd_data[3] |-> !rd_data[5]); // R7
  AST_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    rd_data[7] == (rd_data[5] | rd_data[6])); // R8
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_req == (rd_data[3] & rd_data[7])); // R9
endmodule

bind prn_irq_ctrl prn_irq_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq_req(irq_req), .irq_level(irq_level));

// File: tb/prn_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prn_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       prn_ack = 1'b1;
  logic       prn_fault_n = 1'b1;
  logic       irq_req;
  logic [2:0] irq_level;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prn_irq_ctrl u_prn_irq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .prn_ack(prn_ack), .prn_fault_n(prn_fault_n),
    .irq_req(irq_req), .irq_level(irq_level));

  function automatic logic [7:0] cfg(input logic [2:0] lvl, input logic en,
                                     input logic pol, input logic ca, input logic cf);
    return {1'b0, cf, ca, pol, en, lvl};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic exp;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reg", rd_data, 8'h00);
    chk("R1 irq", {7'd0, irq_req}, 8'd0);

    // R2: level and config readback sweep
    for (int v = 0; v < 32; v++) begin
      wr(cfg(v[2:0], v[3], v[4], 1'b0, 1'b0));
      chk("R2 readback", rd_data, {3'b000, v[4:0]});
      chk("R2 level", {5'd0, irq_level}, {5'd0, v[2:0]});
    end

    // R3/R4/R10: acknowledge sweep over enable, polarity, direction
    for (int pol = 0; pol < 2; pol++)
      for (int en = 0; en < 2; en++)
        for (int rising = 0; rising < 2; rising++) begin
          prn_ack = (rising == 1) ? 1'b0 : 1'b1;
          repeat (4) @(negedge clk);
          wr(cfg(3'd5, en[0], pol[0], 1'b1, 1'b1));
          prn_ack = ~prn_ack;
          @(negedge clk); @(negedge clk);
          chk("R10 not early", {7'd0, rd_data[5]}, 8'd0);
          @(negedge clk);
          exp = en[0] & ((pol == 0) ? (rising == 1) : (rising == 0));
          chk(pol == 0 ? "R3 ack flag" : "R4 ack flag", {7'd0, rd_data[5]}, {7'd0, exp});
          chk("R9 irq", {7'd0, irq_req}, {7'd0, exp});
          chk("R8 summary", {7'd0, rd_data[7]}, {7'd0, exp});
        end
    prn_ack = 1'b1;
    repeat (4) @(negedge clk);

    // R5: fault sweep over enable and direction
    for (int en = 0; en < 2; en++)
      for (int falling = 0; falling < 2; falling++) begin
        prn_fault_n = (falling == 1) ? 1'b1 : 1'b0;
        repeat (4) @(negedge clk);
        wr(cfg(3'd2, en[0], 1'b0, 1'b1, 1'b1));
        prn_fault_n = ~prn_fault_n;
        repeat (3) @(negedge clk);
        chk("R5 fault flag", {7'd0, rd_data[6]}, {7'd0, falling[0]});
        chk("R9 irq fault", {7'd0, irq_req}, {7'd0, en[0] & falling[0]});
      end
    prn_fault_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: write zero keeps, write one clears
    wr(cfg(3'd1, 1'b1, 1'b0, 1'b1, 1'b1));
    prn_fault_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 fault set", {7'd0, rd_data[6]}, 8'd1);
    wr(cfg(3'd1, 1'b1, 1'b0, 1'b0, 1'b0));
    chk("R6 zero keeps", {7'd0, rd_data[6]}, 8'd1);
    wr(cfg(3'd1, 1'b1, 1'b0, 1'b0, 1'b1));
    chk("R6 one clears", {7'd0, rd_data[6]}, 8'd0);
    prn_fault_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: bit 7 ignores writes
    wr(8'h80 | cfg(3'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    chk("R8 write ignored", rd_data, 8'h08);

    // R7: disable clears ack flag and blocks edges, fault kept
    prn_ack = 1'b0;
    repeat (4) @(negedge clk);
    wr(cfg(3'd0, 1'b1, 1'b0, 1'b1, 1'b1));
    prn_ack = 1'b1; prn_fault_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 both set", rd_data & 8'h60, 8'h60);
    wr(cfg(3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R7 ack cleared", {7'd0, rd_data[5]}, 8'd0);
    chk("R7 fault kept", {7'd0, rd_data[6]}, 8'd1);
    chk("R7 irq off", {7'd0, irq_req}, 8'd0);
    prn_ack = 1'b0; repeat (4) @(negedge clk);
    prn_ack = 1'b1; repeat (4) @(negedge clk);
    chk("R7 edge dropped", {7'd0, rd_data[5]}, 8'd0);
    wr(cfg(3'd0, 1'b1, 1'b0, 1'b0, 1'b1));
    chk("R7 no stale", {7'd0, rd_data[5]}, 8'd0);
    prn_fault_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: edge arrives on the clearing write cycle
    prn_ack = 1'b0; repeat (4) @(negedge clk);
    prn_ack = 1'b1; repeat (4) @(negedge clk);
    chk("R10 pre set", {7'd0, rd_data[5]}, 8'd1);
    prn_ack = 1'b0; repeat (4) @(negedge clk);
    prn_ack = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_data = cfg(3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R10 set wins", {7'd0, rd_data[5]}, 8'd1);
    wr(cfg(3'd0, 1'b1, 1'b0, 1'b1, 1'b0));
    chk("R6 ack clear", {7'd0, rd_data[5]}, 8'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule